// File: doc/BRIEF.md
# Platform System Control Port Block

This block is a byte-wide register file on a simple I/O port bus. The bus provides an address, write data, read data, and one read strobe and one write strobe. The block holds the controls that the rest of the platform reads as levels: a reset request, a little-endian mode flag, a disk activity indicator and a four-bit system control field. It also emits two one-cycle pulses that toggle the lock state of a nonvolatile memory. Several ports return fixed identification and equipment bytes. Two ports are plain scratch storage.

The block also holds a map-type flag. This flag selects how a CPU-side offset inside an 8 MB I/O window becomes an I/O port address. In contiguous mode the low 64 KB of the window maps straight through. In sparse mode each 4 KB page of the window carries 32 ports. A purely combinational translator produces that port address for whatever offset is presented.

Top module: `sysctl_io_bridge`

## Requirements
- R1: On reset (rst_n low) the reset request, endian flag, indicator, control field, map-type flag, both scratch bytes and both lock pulses are 0, and io_rdata is 0x00.
- R2: A write to port 0x092 sets rst_req from data bit 0 and le_mode from data bit 1. A read of 0x092 returns 0x00.
- R3: Ports 0x800, 0x802 and 0x803 read as 0xEF, 0xAD and 0xE0. Writes to them change no output and no readable state.
- R4: Ports 0x80C, 0x810, 0x818 and 0x823 read as the constants 0x3C, 0x39, 0x00 and 0x03.
- R5: A write to port 0x808 sets disk_led from data bit 0.
- R6: A write to 0x810 drives lock_pulse[0] high for exactly the cycle after the write edge. A write to 0x812 does the same on lock_pulse[1]. Reading 0x810 still returns 0x39.
- R7: A write to port 0x81C stores data bits 3:0. sys_ctl shows the stored value, and a read returns it zero-extended.
- R8: A write to port 0x850 stores data bit 0 as the map-type flag. A read returns it in bit 0, with bits 7:1 zero.
- R9: With the map-type flag at 0, port_addr equals win_ofs[15:0].
- R10: With the map-type flag at 1, port_addr[4:0] equals win_ofs[4:0] and port_addr[15:5] equals win_ofs[22:12].
- R11: Ports 0x398 and 0x399 are independent 8-bit read/write scratch bytes.
- R12: A read of any port not listed above returns 0xFF. A write to such a port (including 0x812 when read, and 0x814) changes no output and no readable state.
- R13: io_rdata is loaded on the clock edge that samples io_rd and holds its value while io_rd is low. A write takes effect on the edge that samples io_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one access per cycle high |
| io_rd | input | 1 | Read strobe, one access per cycle high |
| io_rdata | output | 8 | Registered read data |
| win_ofs | input | 23 | Offset inside the 8 MB CPU I/O window |
| port_addr | output | 16 | Translated I/O port address |
| rst_req | output | 1 | Reset request level |
| le_mode | output | 1 | Little-endian mode flag |
| disk_led | output | 1 | Disk activity indicator |
| sys_ctl | output | 4 | System control field |
| lock_pulse | output | 2 | Lock-toggle pulses, bit 0 channel 1, bit 1 channel 2 |

## Verification
Register outputs and lock pulses change on the edge that samples io_wr. Read data appears on the edge that samples io_rd. The translated address follows win_ofs and the map-type flag within the same cycle. The bench drives every strobe on a falling edge and keeps it for one cycle. It samples registered results at the next falling edge, one full cycle later. At that edge it checks that a lock pulse is high, and it confirms the pulse has dropped one cycle after that. For the translator, it applies an offset and checks port_addr a short delay later, with no clock edge in between.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  // Port numbers, where the decode depends on exact values
  localparam int unsigned PORT_SYSRST = 'h092;
  localparam int unsigned PORT_CPUCFG = 'h800;
  localparam int unsigned PORT_FEAT   = 'h802;
  localparam int unsigned PORT_MODST  = 'h803;
  localparam int unsigned PORT_LED    = 'h808;
  localparam int unsigned PORT_EQUIP  = 'h80C;
  localparam int unsigned PORT_LOCK1  = 'h810;
  localparam int unsigned PORT_LOCK2  = 'h812;
  localparam int unsigned PORT_KEY    = 'h818;
  localparam int unsigned PORT_CTL    = 'h81C;
  localparam int unsigned PORT_CACHE  = 'h823;
  localparam int unsigned PORT_MAP    = 'h850;
  localparam int unsigned PORT_SCR    = 'h398;
  localparam int unsigned NUM_SCR     = 2;

  // Fixed read values
  localparam int unsigned VAL_CPUCFG = 'hEF;
  localparam int unsigned VAL_FEAT   = 'hAD;
  localparam int unsigned VAL_MODST  = 'hE0;
  localparam int unsigned VAL_EQUIP  = 'h3C;
  localparam int unsigned VAL_EXTFT  = 'h39;
  localparam int unsigned VAL_KEY    = 'h00;
  localparam int unsigned VAL_CACHE  = 'h03;
  localparam int unsigned VAL_NONE   = 'hFF;

  // Sparse mapping geometry
  localparam int unsigned SPARSE_LO  = 5;
  localparam int unsigned PAGE_SHIFT = 12;

endpackage

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CTL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rst_req,
  output logic              le_mode,
  output logic              disk_led,
  output logic [CTL_W-1:0]  sys_ctl,
  output logic              map_sparse,
  output logic [DATA_W-1:0] scr [NUM_SCR],
  output logic [1:0]        lock_pulse
);

  logic hit_sysrst, hit_led, hit_ctl, hit_map, hit_lk1, hit_lk2;
  logic              rst_req_d, le_mode_d, led_d, map_d;
  logic [CTL_W-1:0]  ctl_d;
  logic [1:0]        pulse_d;
  logic [DATA_W-1:0] scr_d [NUM_SCR];

  always_comb begin
    hit_sysrst = wr_en && (addr == ADDR_W'(PORT_SYSRST));
    hit_led    = wr_en && (addr == ADDR_W'(PORT_LED));
    hit_ctl    = wr_en && (addr == ADDR_W'(PORT_CTL));
    hit_map    = wr_en && (addr == ADDR_W'(PORT_MAP));
    hit_lk1    = wr_en && (addr == ADDR_W'(PORT_LOCK1));
    hit_lk2    = wr_en && (addr == ADDR_W'(PORT_LOCK2));
  end

  always_comb begin
    rst_req_d = rst_req;
    le_mode_d = le_mode;
    led_d     = disk_led;
    ctl_d     = sys_ctl;
    map_d     = map_sparse;
    if (hit_sysrst) begin
      rst_req_d = wdata[0];
      le_mode_d = wdata[1];
    end
    if (hit_led) led_d = wdata[0];
    if (hit_ctl) ctl_d = wdata[CTL_W-1:0];
    if (hit_map) map_d = wdata[0];
    pulse_d = {hit_lk2, hit_lk1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req    <= 1'b0;
      le_mode    <= 1'b0;
      disk_led   <= 1'b0;
      sys_ctl    <= '0;
      map_sparse <= 1'b0;
      lock_pulse <= '0;
    end else begin
      rst_req    <= rst_req_d;
      le_mode    <= le_mode_d;
      disk_led   <= led_d;
      sys_ctl    <= ctl_d;
      map_sparse <= map_d;
      lock_pulse <= pulse_d;
    end
  end

  for (genvar i = 0; i < NUM_SCR; i++) begin : g_scr
    logic hit;
    assign hit = wr_en && (addr == ADDR_W'(PORT_SCR + i));
    always_comb scr_d[i] = hit ? wdata : scr[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scr[i] <= '0;
      else if (hit) scr[i] <= scr_d[i];
    end
  end

  // R6: a pulse only ever follows a write to its own port
  a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pulse[0] |-> $past(wr_en && addr == ADDR_W'(PORT_LOCK1)));
  a_r6_pulse2_cause: assert property (@(posedge clk) disable iff (!rst_n)
    lock_pulse[1] |-> $past(wr_en && addr == ADDR_W'(PORT_LOCK2)));
  // R7: the control field moves only on a write to its port
  a_r7_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == ADDR_W'(PORT_CTL)) |=> $stable(sys_ctl));
  // R2: reset request moves only on a write to its port
  a_r2_rst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == ADDR_W'(PORT_SYSRST)) |=> $stable(rst_req));
  // R8: map flag moves only on a write to its port
  a_r8_map_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == ADDR_W'(PORT_MAP)) |=> $stable(map_sparse));

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CTL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTL_W-1:0]  sys_ctl,
  input  logic              map_sparse,
  input  logic [DATA_W-1:0] scr [NUM_SCR],
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = DATA_W'(VAL_NONE);
    case (addr)
      ADDR_W'(PORT_SYSRST): sel = '0;
      ADDR_W'(PORT_CPUCFG): sel = DATA_W'(VAL_CPUCFG);
      ADDR_W'(PORT_FEAT):   sel = DATA_W'(VAL_FEAT);
      ADDR_W'(PORT_MODST):  sel = DATA_W'(VAL_MODST);
      ADDR_W'(PORT_EQUIP):  sel = DATA_W'(VAL_EQUIP);
      ADDR_W'(PORT_LOCK1):  sel = DATA_W'(VAL_EXTFT);
      ADDR_W'(PORT_KEY):    sel = DATA_W'(VAL_KEY);
      ADDR_W'(PORT_CTL):    sel = DATA_W'(sys_ctl);
      ADDR_W'(PORT_CACHE):  sel = DATA_W'(VAL_CACHE);
      ADDR_W'(PORT_MAP):    sel = DATA_W'(map_sparse);
      ADDR_W'(PORT_SCR):    sel = scr[0];
      ADDR_W'(PORT_SCR+1):  sel = scr[1];
      default:              sel = DATA_W'(VAL_NONE);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= sel;
  end

  // R13: read data holds while no read is sampled
  a_r13_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  // R8: the map-type port never returns more than bit 0
  a_r8_map_width: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(PORT_MAP)) |=> (rdata[DATA_W-1:1] == '0));

endmodule

// File: rtl/sysctl_xlate.sv
module sysctl_xlate
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 23
) (
  input  logic              sparse,
  input  logic [OFS_W-1:0]  ofs,
  output logic [ADDR_W-1:0] port
);

  localparam int PAGE_BITS = ADDR_W - SPARSE_LO;

  logic [ADDR_W-1:0] flat, packed_pg;

  always_comb begin
    flat      = ofs[ADDR_W-1:0];
    packed_pg = {ofs[PAGE_SHIFT +: PAGE_BITS], ofs[SPARSE_LO-1:0]};
    port      = sparse ? packed_pg : flat;
  end

  // R10: in sparse mode the low port bits come straight from the offset
  always_comb begin
    if (sparse) a_r10_low_bits: assert (port[SPARSE_LO-1:0] == ofs[SPARSE_LO-1:0]);
  end

endmodule

// File: rtl/sysctl_io_bridge.sv
module sysctl_io_bridge
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CTL_W  = 4,
  parameter int OFS_W  = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [DATA_W-1:0] io_rdata,
  input  logic [OFS_W-1:0]  win_ofs,
  output logic [ADDR_W-1:0] port_addr,
  output logic              rst_req,
  output logic              le_mode,
  output logic              disk_led,
  output logic [CTL_W-1:0]  sys_ctl,
  output logic [1:0]        lock_pulse
);

  logic              map_sparse;
  logic [DATA_W-1:0] scr [NUM_SCR];

  sysctl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_W(CTL_W)) u_regs (
    .clk, .rst_n, .wr_en(io_wr), .addr(io_addr), .wdata(io_wdata),
    .rst_req, .le_mode, .disk_led, .sys_ctl, .map_sparse, .scr, .lock_pulse
  );

  sysctl_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_W(CTL_W)) u_rdmux (
    .clk, .rst_n, .rd_en(io_rd), .addr(io_addr), .sys_ctl, .map_sparse,
    .scr, .rdata(io_rdata)
  );

  sysctl_xlate #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_xlate (
    .sparse(map_sparse), .ofs(win_ofs), .port(port_addr)
  );

  // R6: at most... both pulses never come from one write
  a_r6_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lock_pulse));

endmodule

// File: tb/sysctl_io_bridge_test.sv
module sysctl_io_bridge_test;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] io_addr = 0;
  logic [7:0]  io_wdata = 0;
  logic        io_wr = 0, io_rd = 0;
  logic [7:0]  io_rdata;
  logic [22:0] win_ofs = 0;
  logic [15:0] port_addr;
  logic        rst_req, le_mode, disk_led;
  logic [3:0]  sys_ctl;
  logic [1:0]  lock_pulse;

  int checks = 0, errors = 0;

  // bench model of writable state
  logic       m_rst, m_le, m_led, m_map;
  logic [3:0] m_ctl;
  logic [7:0] m_s0, m_s1;

  always #2 clk = ~clk;

  sysctl_io_bridge uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1;
    @(negedge clk); io_rd = 0; d = io_rdata;
  endtask

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    case (a)
      16'h092: return 8'h00;
      16'h800: return 8'hEF;
      16'h802: return 8'hAD;
      16'h803: return 8'hE0;
      16'h80C: return 8'h3C;
      16'h810: return 8'h39;
      16'h818: return 8'h00;
      16'h81C: return {4'h0, m_ctl};
      16'h823: return 8'h03;
      16'h850: return {7'h0, m_map};
      16'h398: return m_s0;
      16'h399: return m_s1;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic chk_state(input string req);
    logic [7:0] d;
    chk(req, {rst_req, le_mode, disk_led, sys_ctl}, {m_rst, m_le, m_led, m_ctl});
    rd(16'h81C, d); chk(req, d, exp_rd(16'h81C));
    rd(16'h850, d); chk(req, d, exp_rd(16'h850));
    rd(16'h398, d); chk(req, d, m_s0);
    rd(16'h399, d); chk(req, d, m_s1);
  endtask

  function automatic logic [15:0] exp_xl(input logic [22:0] o, input logic sp);
    if (!sp) return 16'(o % 65536);
    return 16'((o % 32) + ((o / 4096) % 2048) * 32);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    m_rst = 0; m_le = 0; m_led = 0; m_map = 0; m_ctl = 0; m_s0 = 0; m_s1 = 0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1", {io_rdata, rst_req, le_mode, disk_led, sys_ctl, lock_pulse}, 0);
    rst_n = 1;
    chk_state("R1");

    // R2: each pattern of bits 1:0, plus don't-care upper bits
    for (int v = 0; v < 4; v++) begin
      wr(16'h092, 8'(v | 8'hF0));
      m_rst = v[0]; m_le = v[1];
      chk("R2", {rst_req, le_mode}, {m_rst, m_le});
      rd(16'h092, d); chk("R2", d, 8'h00);
    end

    // R5
    for (int v = 0; v < 4; v++) begin
      wr(16'h808, 8'(v));
      m_led = v[0];
      chk("R5", disk_led, m_led);
    end

    // R7: all sixteen values, high nibble set
    for (int v = 0; v < 16; v++) begin
      wr(16'h81C, 8'(v | 8'hA0));
      m_ctl = 4'(v);
      chk("R7", sys_ctl, m_ctl);
      rd(16'h81C, d); chk("R7", d, {4'h0, m_ctl});
    end

    // R11: scratch bytes independent
    for (int v = 0; v < 256; v += 17) begin
      wr(16'h398, 8'(v)); m_s0 = 8'(v);
      wr(16'h399, 8'(255 - v)); m_s1 = 8'(255 - v);
      rd(16'h398, d); chk("R11", d, m_s0);
      rd(16'h399, d); chk("R11", d, m_s1);
    end

    // R6: lock pulses
    @(negedge clk); io_addr = 16'h810; io_wdata = 8'h5A; io_wr = 1;
    @(negedge clk); io_wr = 0;
    chk("R6", lock_pulse, 2'b01);
    @(negedge clk); chk("R6", lock_pulse, 2'b00);
    @(negedge clk); io_addr = 16'h812; io_wr = 1;
    @(negedge clk); io_wr = 0;
    chk("R6", lock_pulse, 2'b10);
    @(negedge clk); chk("R6", lock_pulse, 2'b00);
    rd(16'h810, d); chk("R6", d, 8'h39);
    chk_state("R6");

    // R3 / R12: writes to read-only and unmapped ports change nothing
    wr(16'h800, 8'h00); wr(16'h802, 8'h00); wr(16'h803, 8'h00);
    chk_state("R3");
    rd(16'h800, d); chk("R3", d, 8'hEF);
    rd(16'h802, d); chk("R3", d, 8'hAD);
    rd(16'h803, d); chk("R3", d, 8'hE0);
    for (int a = 16'h7F0; a < 16'h900; a++) begin
      if (a != 16'h808 && a != 16'h810 && a != 16'h812 && a != 16'h81C && a != 16'h850)
        wr(16'(a), 8'hFF);
    end
    wr(16'h000, 8'hFF); wr(16'hFFFF, 8'hFF); wr(16'h39A, 8'hFF); wr(16'h397, 8'hFF);
    chk_state("R12");

    // R4 / R12: read sweep over the low 4K ports
    for (int a = 0; a < 4096; a++) begin
      rd(16'(a), d);
      if (a == 16'h80C || a == 16'h810 || a == 16'h818 || a == 16'h823)
        chk("R4", d, exp_rd(16'(a)));
      else
        chk("R12", d, exp_rd(16'(a)));
    end
    rd(16'hF80C, d); chk("R12", d, 8'hFF);

    // R13: data holds without a read strobe
    rd(16'h800, d);
    @(negedge clk); io_addr = 16'h802;
    @(negedge clk); chk("R13", io_rdata, 8'hEF);

    // R9: contiguous translation sweep
    for (int i = 0; i < 2048; i++) begin
      @(negedge clk); win_ofs = 23'((i * 4093 + 7) % 8388608); #1;
      chk("R9", port_addr, exp_xl(win_ofs, 1'b0));
    end
    // R8 / R10: switch to sparse
    wr(16'h850, 8'hFF); m_map = 1;
    rd(16'h850, d); chk("R8", d, 8'h01);
    for (int i = 0; i < 2048; i++) begin
      @(negedge clk); win_ofs = 23'((i * 4099 + 3) % 8388608); #1;
      chk("R10", port_addr, exp_xl(win_ofs, 1'b1));
    end
    @(negedge clk); win_ofs = 23'h7FFFFF; #1;
    chk("R10", port_addr, 16'hFFFF);
    wr(16'h850, 8'hFE); m_map = 0;
    rd(16'h850, d); chk("R8", d, 8'h00);
    @(negedge clk); win_ofs = 23'h7FFFFF; #1;
    chk("R9", port_addr, 16'hFFFF);
    @(negedge clk); win_ofs = 23'h012345; #1;
    chk("R9", port_addr, 16'h2345);

    // R1: reset mid-run clears everything
    wr(16'h850, 8'h01); wr(16'h092, 8'h03); wr(16'h808, 8'h01);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    m_rst = 0; m_le = 0; m_led = 0; m_map = 0; m_ctl = 0; m_s0 = 0; m_s1 = 0;
    chk("R1", {io_rdata, rst_req, le_mode, disk_led, sys_ctl, lock_pulse}, 0);
    rst_n = 1;
    chk_state("R1");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule